// File: doc/BRIEF.md
# Transmit PLCP Frame Assembler

This block builds the nibble stream that a DS3 transmit framer carries as payload. In framed mode it wraps ATM cells in convergence frames. Each frame has twelve rows. A row is two framing bytes, a row-indicator byte, one overhead byte and one 53-byte cell. A trailer of 0xC nibbles ends the frame. Its length alternates between 13 and 14 nibbles over a three-frame stuffing cycle, which keeps the average frame period at 125 µs. In direct-mapped mode the cells run back to back with no overhead, so more of the DS3 bandwidth carries cells.

The downstream framer pulls one nibble per `nib_req` cycle. Cells arrive a byte at a time on a valid/ready interface, with `cell_sop` marking the first byte of a cell. When no cell is waiting at the start of a cell slot, the block sends an idle cell, so the row structure always stays whole. The framing enable comes from a control register bit. It resets to 0, which selects direct mode. The same bit is exported as `mode_plcp` so that the receive-side processor can follow it.

Top module: `plcp_tx_assembler`

## Requirements
- R1: While reset is asserted, and after it, the outputs read `nib_out`=0, `frame_done`=0 and `mode_plcp`=0. The block stays in direct mode and forms no frames until `cfg_plcp_en` is set to 1.
- R2: `mode_plcp` exports the enable bit. A change of `cfg_plcp_en` takes effect on the first requested nibble of the next cell (in direct mode) or of the next frame (in framed mode), so that a frame already started is always completed.
- R3: Framed mode has 12 rows of 114 nibbles. Each row sends, in this order: 0xF6, 0x28, the row indicator, the overhead byte, then 53 cell bytes. Every byte goes high nibble first.
- R4: The row indicator of row r (0 = first) is ((11-r)*4)+1, which gives 0x2D down to 0x01. The overhead byte is 0x00 in rows 0 to 10. In row 11 it carries the stuffing code: 0xFF in phase 0, 0x00 in phase 1 and 0x66 in phase 2.
- R5: After row 11 comes a trailer of 0xC nibbles. It is 14 nibbles long in stuffing phase 1 and 13 nibbles in phases 0 and 2. The phase advances 0,1,2,0 at each frame end and restarts at 0 when framed mode is entered.
- R6: `frame_done` is 1 for exactly the period of the last trailer nibble. It is never 1 in direct mode.
- R7: Direct mode sends 53-byte cells back to back, 106 nibbles each, with no framing or overhead bytes.
- R8: If a cell slot starts while `cell_valid` and `cell_sop` are not both 1, an idle cell is sent: bytes 00 00 00 01 52, followed by 48 bytes of 0x6A.
- R9: A user cell is accepted when `cell_valid` and `cell_sop` are both 1 at the first nibble of a slot. `cell_ready` is 1 only on `nib_req` cycles that emit the high nibble of that cell's bytes, and one byte is taken on each of those cycles.
- R10: While `nib_req` is 0, `nib_out`, `frame_done` and `mode_plcp` hold their values, and no cell byte is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_plcp_en | input | 1 | Register bit: 1 = framed mode, 0 = direct-mapped |
| cell_valid | input | 1 | Cell byte present |
| cell_sop | input | 1 | First byte of a cell |
| cell_data | input | 8 | Cell byte |
| cell_ready | output | 1 | Cell byte taken this cycle |
| nib_req | input | 1 | Nibble request from the DS3 framer |
| nib_out | output | 4 | Payload nibble, updated on each request |
| frame_done | output | 1 | High during the final trailer nibble |
| mode_plcp | output | 1 | Active mode, exported to the receive side |

## Verification
The frame-end strobe and a mode change can meet at the same point. When the enable is cleared partway through a frame, the last trailer nibble must still raise `frame_done`. The switch to direct mode must then happen on the very next request, not one nibble early. The bench clears the enable in the middle of the last table frame. It checks that `mode_plcp` stays 1, that the stream completes with exactly one strobe, and that the next nibble already starts a bare cell. A stall of the request line in the middle of a cell row is also checked: the outputs must hold, and no byte may be taken.

// File: rtl/plcp_tx_pkg.sv
package plcp_tx_pkg;
  localparam int BYTE_W      = 8;
  localparam int NIB_W       = 4;
  localparam int OH_BYTES    = 4;
  localparam int TRL_W       = 4;
  localparam int STUFF_CYCLE = 3;
  localparam int PH_W        = 2;
  localparam logic [BYTE_W-1:0] SYNC_HI   = 8'hF6;
  localparam logic [BYTE_W-1:0] SYNC_LO   = 8'h28;
  localparam logic [BYTE_W-1:0] FILL_BYTE = 8'h6A;
  localparam logic [NIB_W-1:0]  TRL_NIB   = 4'hC;

  // row indicator: counts down from the first row to the last
  function automatic logic [BYTE_W-1:0] row_mark(input int row, input int rows);
    return BYTE_W'((rows - 1 - row) * 4 + 1);
  endfunction

  // stuffing phase code carried in the last overhead byte
  function automatic logic [BYTE_W-1:0] stuff_code(input int ph);
    case (ph)
      0:       return 8'hFF;
      1:       return 8'h00;
      default: return 8'h66;
    endcase
  endfunction

  function automatic int trailer_len(input int ph);
    return (ph == 1) ? 14 : 13;
  endfunction

  function automatic logic [BYTE_W-1:0] idle_byte(input int k);
    if (k < 3)       return 8'h00;
    else if (k == 3) return 8'h01;
    else if (k == 4) return 8'h52;
    else             return FILL_BYTE;
  endfunction
endpackage

// File: rtl/plcp_tx_position.sv
module plcp_tx_position
  import plcp_tx_pkg::*;
#(
  parameter int ROWS       = 12,
  parameter int CELL_BYTES = 53,
  parameter int CW         = 7,
  parameter int RW         = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            framed,
  input  logic            restart,
  output logic [RW-1:0]   row,
  output logic [CW-1:0]   col,
  output logic            in_trl,
  output logic [PH_W-1:0] phase,
  output logic            at_start,
  output logic            last_trl
);
  localparam int ROW_NIBS  = 2 * (CELL_BYTES + OH_BYTES);
  localparam int CELL_NIBS = 2 * CELL_BYTES;

  logic [TRL_W-1:0] trl_idx;

  assign at_start = (col == '0) && (row == '0) && !in_trl;
  assign last_trl = in_trl && (int'(trl_idx) == trailer_len(int'(phase)) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row <= '0; col <= '0; in_trl <= 1'b0; trl_idx <= '0; phase <= '0;
    end else if (step) begin
      if (restart) begin
        row <= '0; col <= CW'(1); in_trl <= 1'b0; trl_idx <= '0; phase <= '0;
      end else if (!framed) begin
        col <= (int'(col) == CELL_NIBS - 1) ? '0 : col + 1'b1;
      end else if (in_trl) begin
        if (last_trl) begin
          in_trl  <= 1'b0;
          trl_idx <= '0;
          phase   <= (int'(phase) == STUFF_CYCLE - 1) ? '0 : phase + 1'b1;
        end else begin
          trl_idx <= trl_idx + 1'b1;
        end
      end else if (int'(col) == ROW_NIBS - 1) begin
        col <= '0;
        if (int'(row) == ROWS - 1) begin
          row    <= '0;
          in_trl <= 1'b1;
        end else begin
          row <= row + 1'b1;
        end
      end else begin
        col <= col + 1'b1;
      end
    end
  end
endmodule

// File: rtl/plcp_tx_nibble_mux.sv
module plcp_tx_nibble_mux
  import plcp_tx_pkg::*;
#(
  parameter int ROWS       = 12,
  parameter int CELL_BYTES = 53,
  parameter int CW         = 7,
  parameter int RW         = 4
) (
  input  logic              framed,
  input  logic [RW-1:0]     row,
  input  logic [CW-1:0]     col,
  input  logic              in_trl,
  input  logic [PH_W-1:0]   phase,
  input  logic              user_sel,
  input  logic              cell_valid,
  input  logic [BYTE_W-1:0] cell_data,
  input  logic [NIB_W-1:0]  lo_hold,
  output logic [NIB_W-1:0]  nib,
  output logic [NIB_W-1:0]  lo_next,
  output logic              cell_hi,
  output logic              cell_first
);
  int                bidx;
  int                k;
  logic              hi;
  logic              in_cell;
  logic [BYTE_W-1:0] oh_b;
  logic [BYTE_W-1:0] cell_b;

  always_comb begin
    bidx    = int'(col >> 1);
    hi      = ~col[0];
    k       = framed ? bidx - OH_BYTES : bidx;
    in_cell = !in_trl && (!framed || bidx >= OH_BYTES);
    if (user_sel) cell_b = cell_valid ? cell_data : FILL_BYTE;
    else          cell_b = idle_byte(k);
    case (bidx)
      0:       oh_b = SYNC_HI;
      1:       oh_b = SYNC_LO;
      2:       oh_b = row_mark(int'(row), ROWS);
      default: oh_b = (int'(row) == ROWS - 1) ? stuff_code(int'(phase)) : '0;
    endcase
    if (in_trl)       nib = TRL_NIB;
    else if (in_cell) nib = hi ? cell_b[7:4] : lo_hold;
    else              nib = hi ? oh_b[7:4] : oh_b[3:0];
    lo_next    = cell_b[3:0];
    cell_hi    = in_cell && hi;
    cell_first = in_cell && hi && (k == 0);
  end
endmodule

// File: rtl/plcp_tx_assembler.sv
module plcp_tx_assembler
  import plcp_tx_pkg::*;
#(
  parameter int ROWS       = 12,
  parameter int CELL_BYTES = 53
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_plcp_en,
  input  logic              cell_valid,
  input  logic              cell_sop,
  input  logic [BYTE_W-1:0] cell_data,
  output logic              cell_ready,
  input  logic              nib_req,
  output logic [NIB_W-1:0]  nib_out,
  output logic              frame_done,
  output logic              mode_plcp
);
  localparam int CW = $clog2(2 * (CELL_BYTES + OH_BYTES));
  localparam int RW = $clog2(ROWS);

  logic              mode_q, user_q, fd_q;
  logic [NIB_W-1:0]  nib_q, lo_hold_q, nib_c, lo_next;
  logic [RW-1:0]     row;
  logic [CW-1:0]     col;
  logic [PH_W-1:0]   phase;
  logic              in_trl, at_start, last_trl, cell_hi, cell_first;
  logic              switch_mode, eff_mode, user_now;

  // named events for the checker
  logic ev_frame_end, ev_cell_start, ev_mode_switch;

  assign switch_mode = at_start && (cfg_plcp_en != mode_q);
  assign eff_mode    = switch_mode ? cfg_plcp_en : mode_q;
  assign user_now    = cell_first ? (cell_valid && cell_sop) : user_q;
  assign cell_ready  = nib_req && cell_hi && user_now;

  assign ev_frame_end   = nib_req && last_trl;
  assign ev_cell_start  = nib_req && cell_first;
  assign ev_mode_switch = nib_req && switch_mode;

  plcp_tx_position #(.ROWS(ROWS), .CELL_BYTES(CELL_BYTES), .CW(CW), .RW(RW)) u_pos (
    .clk(clk), .rst_n(rst_n), .step(nib_req), .framed(eff_mode), .restart(switch_mode),
    .row(row), .col(col), .in_trl(in_trl), .phase(phase),
    .at_start(at_start), .last_trl(last_trl)
  );

  plcp_tx_nibble_mux #(.ROWS(ROWS), .CELL_BYTES(CELL_BYTES), .CW(CW), .RW(RW)) u_mux (
    .framed(eff_mode), .row(row), .col(col), .in_trl(in_trl), .phase(phase),
    .user_sel(user_now), .cell_valid(cell_valid), .cell_data(cell_data),
    .lo_hold(lo_hold_q), .nib(nib_c), .lo_next(lo_next),
    .cell_hi(cell_hi), .cell_first(cell_first)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0; user_q <= 1'b0; fd_q <= 1'b0;
      nib_q <= '0; lo_hold_q <= '0;
    end else if (nib_req) begin
      mode_q <= eff_mode;
      nib_q  <= nib_c;
      fd_q   <= last_trl;
      if (cell_first) user_q    <= user_now;
      if (cell_hi)    lo_hold_q <= lo_next;
    end
  end

  assign nib_out    = nib_q;
  assign frame_done = fd_q;
  assign mode_plcp  = mode_q;
endmodule

// File: rtl/plcp_tx_checker.sv
module plcp_tx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_plcp_en,
  input logic       nib_req,
  input logic [3:0] nib_out,
  input logic       frame_done,
  input logic       mode_plcp,
  input logic       cell_ready,
  input logic       ev_frame_end,
  input logic       ev_mode_switch
);
  // R1: stays direct while the enable is low
  assert_stay_direct_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_plcp && !cfg_plcp_en) |=> !mode_plcp);

  // R2: a switch lands on the requested mode
  assert_switch_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mode_switch |=> (mode_plcp == $past(cfg_plcp_en)));

  // R6: strobe follows the last trailer nibble, lasts one nibble, framed only
  assert_strobe_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_end |=> frame_done);
  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && nib_req) |=> !frame_done);
  assert_strobe_framed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> mode_plcp);

  // R9: bytes taken only on requests
  assert_ready_on_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cell_ready |-> nib_req);

  // R10: outputs hold without a request
  assert_hold_nib_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !nib_req |=> $stable(nib_out));
  assert_hold_ctrl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !nib_req |=> ($stable(frame_done) && $stable(mode_plcp)));
endmodule

bind plcp_tx_assembler plcp_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_plcp_en(cfg_plcp_en), .nib_req(nib_req),
  .nib_out(nib_out), .frame_done(frame_done), .mode_plcp(mode_plcp),
  .cell_ready(cell_ready), .ev_frame_end(ev_frame_end), .ev_mode_switch(ev_mode_switch)
);

// File: tb/plcp_tx_assembler_bench.sv
module plcp_tx_assembler_bench;
  logic       clk = 1'b0, rst_n = 1'b0, cfg = 1'b0;
  logic       cell_valid = 1'b0, cell_sop = 1'b0, nib_req = 1'b0;
  logic [7:0] cell_data = 8'h00;
  logic       cell_ready, frame_done, mode_plcp;
  logic [3:0] nib_out;

  plcp_tx_assembler u_plcp_tx_assembler (
    .clk(clk), .rst_n(rst_n), .cfg_plcp_en(cfg), .cell_valid(cell_valid),
    .cell_sop(cell_sop), .cell_data(cell_data), .cell_ready(cell_ready),
    .nib_req(nib_req), .nib_out(nib_out), .frame_done(frame_done), .mode_plcp(mode_plcp)
  );

  always #10 clk = ~clk;

  // frame table: source active, expected trailer length, expected stuffing code
  localparam int         NFR = 5;
  localparam bit         T_FEED [NFR] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam int         T_LEN  [NFR] = '{13, 14, 13, 13, 14};
  localparam logic [7:0] T_C1   [NFR] = '{8'hFF, 8'h00, 8'h66, 8'hFF, 8'h00};
  localparam logic [7:0] MARKS  [12]  = '{8'h2D, 8'h29, 8'h25, 8'h21, 8'h1D, 8'h19,
                                          8'h15, 8'h11, 8'h0D, 8'h09, 8'h05, 8'h01};

  int checks = 0, errors = 0;
  int bc = 0, br = 0, bt = 0, sc = 0, sk = 0, cur_len = 13, mm = 0, fdc = 0;
  bit bm = 0, btr = 0, buser = 0, feed = 0;
  logic [7:0] bbyte = 8'h00, cur_c1 = 8'hFF;
  string first = "";

  function automatic logic [7:0] src_byte(input int c, input int k);
    return 8'((c * 7 + k * 3 + 1) & 255);
  endfunction

  function automatic logic [7:0] idle_b(input int k);
    case (k)
      0, 1, 2: return 8'h00;
      3:       return 8'h01;
      4:       return 8'h52;
      default: return 8'h6A;
    endcase
  endfunction

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
    end
  endtask

  task automatic seg_begin();
    mm = 0; fdc = 0; first = "";
  endtask

  task automatic step();
    logic [7:0] eb;
    logic [3:0] en;
    logic efd, ecr, rdy;
    int b, k;
    bit hi;
    @(negedge clk);
    if (bc == 0 && br == 0 && !btr && cfg != bm) bm = cfg;
    nib_req = 1'b1; cell_valid = feed; cell_sop = (sk == 0); cell_data = src_byte(sc, sk);
    efd = 1'b0; ecr = 1'b0;
    b = bc / 2; hi = (bc % 2 == 0);
    if (bm && btr) begin
      en = 4'hC; efd = (bt == cur_len - 1);
    end else if (bm && b < 4) begin
      eb = (b == 0) ? 8'hF6 : (b == 1) ? 8'h28 : (b == 2) ? MARKS[br] :
           ((br == 11) ? cur_c1 : 8'h00);
      en = hi ? eb[7:4] : eb[3:0];
    end else begin
      k = bm ? b - 4 : b;
      if (hi && k == 0) buser = feed && (sk == 0);
      if (hi) bbyte = buser ? src_byte(sc, sk) : idle_b(k);
      en = hi ? bbyte[7:4] : bbyte[3:0];
      ecr = hi && buser;
    end
    #1 rdy = cell_ready;
    @(posedge clk); #2;
    if (frame_done) fdc++;
    if (nib_out !== en || frame_done !== efd || rdy !== ecr) begin
      if (mm == 0)
        first = $sformatf("pos r%0d c%0d t%0d nib %h/%h fd %b/%b rdy %b/%b",
                          br, bc, bt, nib_out, en, frame_done, efd, rdy, ecr);
      mm++;
    end
    if (rdy && cell_valid) begin
      sk++;
      if (sk == 53) begin sk = 0; sc++; end
    end
    if (bm) begin
      if (btr) begin
        if (bt == cur_len - 1) begin btr = 0; bt = 0; end else bt++;
      end else begin
        bc++;
        if (bc == 114) begin
          bc = 0; br++;
          if (br == 12) begin br = 0; btr = 1; bt = 0; end
        end
      end
    end else begin
      bc++;
      if (bc == 106) bc = 0;
    end
  endtask

  task automatic stream_chk(input string tag);
    chk(mm == 0, {tag, " stream mismatches (expected 0), first: ", first}, mm, 0);
  endtask

  task automatic stall();
    logic [3:0] held;
    bit seen;
    seen = 0;
    @(negedge clk);
    nib_req = 1'b0; cell_valid = 1'b1; cell_sop = 1'b1;
    held = nib_out;
    repeat (5) begin
      @(negedge clk); #1;
      if (cell_ready) seen = 1;
    end
    chk(nib_out == held, "R10 nib_out held during stall", nib_out, held);
    chk(!seen, "R10 no byte taken during stall", seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    checks++; errors++;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(nib_out == 4'h0, "R1 reset nib_out", nib_out, 0);
    chk(frame_done == 1'b0, "R1 reset frame_done", frame_done, 0);
    chk(mode_plcp == 1'b0, "R1 reset mode_plcp", mode_plcp, 0);
    @(negedge clk); rst_n = 1'b1;

    // direct mode, no source: idle cells
    seg_begin(); feed = 0;
    repeat (212) step();
    stream_chk("R8 R7 direct idle cells");
    chk(fdc == 0, "R6 R1 no strobe while disabled", fdc, 0);
    chk(mode_plcp == 1'b0, "R1 still direct", mode_plcp, 0);

    // direct mode with user cells
    seg_begin(); feed = 1;
    repeat (212) step();
    stream_chk("R7 R9 direct user cells");
    chk(fdc == 0, "R6 no strobe in direct mode", fdc, 0);

    // framed mode, table-driven
    cfg = 1'b1;
    for (int i = 0; i < NFR; i++) begin
      seg_begin();
      feed = T_FEED[i]; cur_len = T_LEN[i]; cur_c1 = T_C1[i];
      for (int s = 0; s < 12 * 114 + T_LEN[i]; s++) begin
        if (i == 2 && s == 300) stall();
        if (i == 4 && s == 500) cfg = 1'b0;
        step();
        if (i == 0 && s == 0) chk(mode_plcp == 1'b1, "R2 framed mode at cell boundary", mode_plcp, 1);
        if (i == 4 && s == 501) chk(mode_plcp == 1'b1, "R2 frame completes after disable", mode_plcp, 1);
      end
      stream_chk($sformatf("R3 R4 R5 R8 R9 frame %0d", i));
      chk(fdc == 1, $sformatf("R6 one strobe in frame %0d", i), fdc, 1);
    end

    // back to direct right after the frame end
    seg_begin(); feed = 1;
    step();
    chk(mode_plcp == 1'b0, "R2 direct on next nibble after frame", mode_plcp, 0);
    repeat (105) step();
    stream_chk("R7 direct after disable");
    chk(fdc == 0, "R6 no strobe after disable", fdc, 0);

    // reset in the middle of a cell
    repeat (40) step();
    @(negedge clk);
    rst_n = 1'b0; nib_req = 1'b0;
    #2;
    chk(nib_out == 4'h0, "R1 mid-run reset nib_out", nib_out, 0);
    chk(mode_plcp == 1'b0, "R1 mid-run reset mode", mode_plcp, 0);
    bc = 0; br = 0; bt = 0; btr = 0; bm = 0; sk = 0; sc = sc + 1;
    @(negedge clk); rst_n = 1'b1;
    seg_begin(); feed = 0;
    repeat (106) step();
    stream_chk("R1 R8 idle cell after reset");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule